// File: doc/BRIEF.md
# Serial Control Register Port

This block receives control writes over a four-wire serial link and keeps them in a small bank of 8-bit configuration registers. The host lowers chip select, then clocks in bytes MSB first. The first byte is a 7-bit device identifier followed by a direction bit. The second byte sets the register pointer and an auto-advance flag. Every byte after that is data, written to the register the pointer selects.

All serial inputs are resynchronised to the system clock and their edges are detected there, so the serial clock must run several times slower than `clk_i`. Registers 1 to 12 can be written. Register 13 returns a fixed revision code. Addresses 0, 14 and 15 do not exist. The block also reports, as a sticky flag, that the serial format has been in use since reset. It sets this flag on the first falling edge of chip select.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, registers 3, 4 and 5 read 8'h09 (low nibble 1001), every other writable register (1, 2, 6 to 12) reads 8'h00, and register 13 reads 8'h01. Register a appears at `regs_o[(a-1)*8 +: 8]`.
- R2: Data on `mosi_i` is taken on each rising edge of `sclk_i` while `cs_ni` is low, MSB first. The first byte of a transaction must equal 8'h20, which is identifier 7'b0010000 with direction bit 0 (write). Any other first byte, including the read form 8'h21, makes the block ignore the whole transaction.
- R3: In the second byte, bit 7 is the auto-advance flag and bits 3:0 are the register pointer. Bits 6:4 have no effect.
- R4: When the flag is 1, the pointer steps by one after each data byte and wraps from 15 to 0.
- R5: When the flag is 0, every data byte of the transaction goes to the same register.
- R6: Writes aimed at addresses 0, 13, 14 or 15 change no register. Register 13 always reads 8'h01.
- R7: Raising `cs_ni` ends the transaction and drops any partly received byte. The next transaction starts again with the identifier byte.
- R8: `spi_mode_o` is 0 after reset. It goes to 1 after the first falling edge of `cs_ni` and stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial bit clock |
| mosi_i | input | 1 | Serial data in |
| spi_mode_o | output | 1 | Sticky flag: serial format detected |
| regs_o | output | 104 | Register bank contents, register a at bits (a-1)*8 +: 8 |

## Verification
The assertions check the following on every cycle:
- the mode flag never drops once it is set;
- the bit counter is cleared while chip select is high;
- the pointer steps by one after a data byte when the flag is set, and holds when it is clear;
- a skipped transaction issues no write;
- the register bank stays unchanged when no write is issued or when a write targets the read-only address.

Other behaviour shows only in the bench's scenarios, because it depends on whole transactions. This covers:
- the identifier and direction filtering;
- the masking of reserved bits in the pointer byte;
- the pointer wrap past address 15;
- the reset defaults;
- recovery after a transaction that stops part-way through a byte.

// File: rtl/spi_reg_port_pkg.sv
package spi_reg_port_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_ID   = 2'd0,
    ST_PTR  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } txn_state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_reg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!active_i) begin
        cnt_q <= '0;  // partial byte dropped
      end else if (bit_stb_i) begin
        sh_q  <= {sh_q[DATA_W-3:0], bit_i};
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(DATA_W - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, bit_i};
        end
      end
    end
  end

  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_reg_port_pkg::*;
#(
  parameter logic [6:0] CHIP_ID = 7'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  txn_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              incr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ID;
      ptr_q     <= '0;
      incr_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!active_i) begin
        state_q <= ST_ID;
      end else if (byte_vld_i) begin
        unique case (state_q)
          ST_ID:   state_q <= (byte_i == {CHIP_ID, 1'b0}) ? ST_PTR : ST_SKIP;
          ST_PTR: begin
            incr_q  <= byte_i[DATA_W-1];
            ptr_q   <= byte_i[ADDR_W-1:0];
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= byte_i;
            if (incr_q) ptr_q <= ptr_q + ADDR_W'(1);
          end
          default: state_q <= ST_SKIP;
        endcase
      end
    end
  end

  p_ptr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && byte_vld_i && state_q == ST_DATA && incr_q)
      |=> ptr_q == $past(ptr_q) + ADDR_W'(1));
  p_ptr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && byte_vld_i && state_q == ST_DATA && !incr_q) |=> $stable(ptr_q));
  p_skip_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |=> !wr_en_o);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_port_pkg::*;
#(
  parameter int         NUM_REGS    = 13,
  parameter int         MIX_FIRST   = 3,
  parameter int         MIX_LAST    = 5,
  parameter logic [3:0] MIX_DEFAULT = 4'h9,
  parameter logic [3:0] REV_CODE    = 4'h1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int RO_ADDR = NUM_REGS;

  for (genvar a = 1; a <= NUM_REGS; a++) begin : g_reg
    if (a == RO_ADDR) begin : g_ro
      assign regs_o[(a-1)*DATA_W +: DATA_W] = {4'h0, REV_CODE};
    end else begin : g_rw
      localparam logic [DATA_W-1:0] DFLT =
        (a >= MIX_FIRST && a <= MIX_LAST) ? {4'h0, MIX_DEFAULT} : '0;
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    r_q <= DFLT;
        else if (wr_en_i && wr_addr_i == ADDR_W'(a))    r_q <= wr_data_i;
      end
      assign regs_o[(a-1)*DATA_W +: DATA_W] = r_q;
    end
  end

  p_ro_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(RO_ADDR)) |=> $stable(regs_o));
  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_port_pkg::*;
#(
  parameter int         NUM_REGS    = 13,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] CHIP_ID     = 7'h10,
  parameter int         MIX_FIRST   = 3,
  parameter int         MIX_LAST    = 5,
  parameter logic [3:0] MIX_DEFAULT = 4'h9,
  parameter logic [3:0] REV_CODE    = 4'h1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  output logic                       spi_mode_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic cs_q, cs_rise, cs_fall;
  logic sclk_q, sclk_rise, sclk_fall;
  logic mosi_q, mosi_rise, mosi_fall;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_d;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              mode_q;

  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_q), .rise_o(cs_rise), .fall_o(cs_fall));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_q), .rise_o(sclk_rise), .fall_o(sclk_fall));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi_sync (
    .clk_i, .rst_ni, .d_i(mosi_i), .q_o(mosi_q), .rise_o(mosi_rise), .fall_o(mosi_fall));

  spi_byte_rx u_rx (
    .clk_i, .rst_ni, .active_i(~cs_q), .bit_stb_i(sclk_rise), .bit_i(mosi_q),
    .byte_vld_o(byte_vld), .byte_o(byte_d));

  spi_txn_ctrl #(.CHIP_ID(CHIP_ID)) u_ctrl (
    .clk_i, .rst_ni, .active_i(~cs_q), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  spi_reg_bank #(
    .NUM_REGS(NUM_REGS), .MIX_FIRST(MIX_FIRST), .MIX_LAST(MIX_LAST),
    .MIX_DEFAULT(MIX_DEFAULT), .REV_CODE(REV_CODE)
  ) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o);

  // serial format latched on first select edge, held until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 1'b0;
    else if (cs_fall) mode_q <= 1'b1;
  end
  assign spi_mode_o = mode_q;

  p_mode_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q);
  p_mode_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> mode_q);

  logic unused_edges;
  assign unused_edges = ^{cs_rise, sclk_fall, mosi_rise, mosi_fall, sclk_q};
endmodule

// File: tb/sim_spi_reg_port.sv
module sim_spi_reg_port;
  localparam int NR = 13;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk_i = 1'b0, mosi_i = 1'b0;
  logic spi_mode_o;
  logic [NR*8-1:0] regs_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [1:NR];
  logic [7:0] buf_b [0:15];

  always #2 clk = ~clk;  // 250 MHz

  spi_reg_port u0 (.clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .mosi_i, .spi_mode_o, .regs_o);

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_i = b[i];
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(4);
      sclk_i = 1'b0;
    end
  endtask

  // exp model per requirements R2..R6
  task automatic model(input int n);
    logic [3:0] p;
    logic inc;
    if (n < 2 || buf_b[0] != 8'h20) return;
    inc = buf_b[1][7];
    p   = buf_b[1][3:0];
    for (int i = 2; i < n; i++) begin
      if (p >= 4'd1 && p <= 4'd12) exp_r[p] = buf_b[i];
      if (inc) p = p + 4'd1;
    end
  endtask

  task automatic run_txn(input int n);
    wait_clk(2);
    cs_ni = 1'b0;
    wait_clk(6);
    for (int i = 0; i < n; i++) send_bits(buf_b[i], 8);
    wait_clk(6);
    cs_ni = 1'b1;
    wait_clk(8);
    model(n);
  endtask

  task automatic check_bank(input string req);
    checks++;
    for (int a = 1; a <= NR; a++) begin
      if (regs_o[(a-1)*8 +: 8] !== exp_r[a]) begin
        errors++;
        $display("FAIL %s reg %0d actual %h expected %h", req, a, regs_o[(a-1)*8 +: 8], exp_r[a]);
        break;
      end
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int a = 1; a <= NR; a++) exp_r[a] = (a >= 3 && a <= 5) ? 8'h09 : 8'h00;
    exp_r[13] = 8'h01;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    check_bank("R1");
    check_bit("R8 reset", spi_mode_o, 1'b0);

    // R4 increment writes 1,2,3
    buf_b[0] = 8'h20; buf_b[1] = 8'h81; buf_b[2] = 8'hA1; buf_b[3] = 8'hB2; buf_b[4] = 8'hC3;
    run_txn(5);
    check_bit("R8 latch", spi_mode_o, 1'b1);
    check_bank("R4 incr");

    // R5 no increment: all to reg 7
    buf_b[0] = 8'h20; buf_b[1] = 8'h07; buf_b[2] = 8'h11; buf_b[3] = 8'h22; buf_b[4] = 8'h33;
    run_txn(5);
    check_bank("R5 hold");
    check_bit("R5 reg8 untouched", regs_o[7*8 +: 8] == 8'h00, 1'b1);

    // R3 reserved bits 6:4 ignored
    buf_b[0] = 8'h20; buf_b[1] = 8'hF2; buf_b[2] = 8'h5A; buf_b[3] = 8'h6B;
    run_txn(4);
    check_bank("R3 reserved bits");

    // R4 R6 wrap: 0E,0F,00 ignored, 01 written
    buf_b[0] = 8'h20; buf_b[1] = 8'h8E; buf_b[2] = 8'hE0; buf_b[3] = 8'hE1;
    buf_b[4] = 8'hE2; buf_b[5] = 8'hE3;
    run_txn(6);
    check_bank("R4 wrap");

    // R6 read-only 0D
    buf_b[0] = 8'h20; buf_b[1] = 8'h0D; buf_b[2] = 8'hFF;
    run_txn(3);
    check_bank("R6 readonly");

    // R2 read direction and wrong id
    buf_b[0] = 8'h21; buf_b[1] = 8'h04; buf_b[2] = 8'h77;
    run_txn(3);
    check_bank("R2 read bit");
    buf_b[0] = 8'h22; buf_b[1] = 8'h04; buf_b[2] = 8'h77;
    run_txn(3);
    check_bank("R2 wrong id");

    // R7 abort mid data byte, then mid id byte, then valid txn
    wait_clk(2); cs_ni = 1'b0; wait_clk(6);
    send_bits(8'h20, 8); send_bits(8'h06, 8); send_bits(8'h99, 3);
    wait_clk(4); cs_ni = 1'b1; wait_clk(8);
    check_bank("R7 partial dropped");
    wait_clk(2); cs_ni = 1'b0; wait_clk(6);
    send_bits(8'h20, 5);
    wait_clk(4); cs_ni = 1'b1; wait_clk(8);
    buf_b[0] = 8'h20; buf_b[1] = 8'h06; buf_b[2] = 8'h3C;
    run_txn(3);
    check_bank("R7 restart");

    // random mix of R2..R6
    for (int t = 0; t < 40; t++) begin
      int n;
      n = 2 + int'($urandom_range(5, 1));
      buf_b[0] = ($urandom_range(9, 0) < 8) ? 8'h20 : 8'($urandom);
      buf_b[1] = 8'($urandom);
      for (int i = 2; i < n; i++) buf_b[i] = 8'($urandom);
      run_txn(n);
      check_bank("R2 R4 R5 random");
    end
    check_bit("R8 sticky", spi_mode_o, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule